// File: doc/BRIEF.md
# Layer Trigger Request and Time-over-Threshold Recorder

This block sits between one detector layer's wired-OR hit signal and the trigger and readout logic of a tracking layer. The raw OR is asynchronous to the system clock, so the block first synchronizes it. It then drives a trigger request toward the downstream coincidence logic. In follow mode the request is the synchronized OR, unchanged. In one-shot mode each new rising edge of the OR produces a request pulse whose length in clock periods is programmable.

Independently, every trigger acknowledge starts a time-over-threshold measurement. The measurement counts the clock periods during which the synchronized OR remains high, so the result is the pulse width less the loop latency from request to acknowledge. The count saturates at a fixed ceiling, so the measurement always ends in bounded time. Results go into a small ring of slots that shadow the event buffers. Readout frees the slots in the order they were taken.

Top module: `lyr_trig_tot`

## Requirements
- R1: After reset, `trig_req`, `tot_rdy` and `tot_ovf` are 0 and `tot_head` is 0.
- R2: With `mode_sel`=0 (follow), `trig_req` equals `layer_or` as captured by a two-stage synchronizer. A change driven between edges appears at the output after the second following rising edge.
- R3: With `mode_sel`=1 (one-shot), a rising `layer_or` raises `trig_req` after the third following rising edge. The request then stays high for exactly `pulse_len` clock periods.
- R4: In one-shot mode, a new rising edge of `layer_or` that is seen while a request pulse is active neither restarts nor lengthens that pulse.
- R5: In one-shot mode, `pulse_len`=0 produces no request.
- R6: A `trig_ack` sampled at edge P0 records a count. The count is the number of consecutive edges P1, P2, … at which the synchronized OR is high. The measurement ends at the first edge where the synchronized OR is low, and the slot's ready bit is set at that edge.
- R7: If the synchronized OR is already low at the edge after the acknowledge, the recorded count is 0.
- R8: The count saturates at 1000. A measurement that reaches 1000 ends on the next edge, even if the OR is still high.
- R9: Slot i's count sits at `tot_cnt[i*10 +: 10]` and its ready flag at `tot_rdy[i]`. Acknowledges take the slots in turn, and `tot_head` names the oldest slot. `slot_release` clears that slot and advances `tot_head` only if the slot is ready; otherwise the release is ignored.
- R10: An acknowledge that arrives while both slots are taken sets the sticky `tot_ovf` and changes no slot. `tot_ovf` is cleared only by reset.
- R11: An acknowledge that arrives while a measurement is running closes that measurement with the count reached so far. It then opens a fresh measurement in the next slot.
- R12: An acknowledge and a release in the same cycle judge occupancy before the release. With both slots taken, the acknowledge overflows while the release still frees the head slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| layer_or | input | 1 | Asynchronous layer hit OR |
| trig_ack | input | 1 | Trigger acknowledge, one-cycle pulse |
| mode_sel | input | 1 | 0 = follow, 1 = one-shot request |
| pulse_len | input | 8 | One-shot request length in clock periods |
| slot_release | input | 1 | Frees the oldest slot once it is ready |
| trig_req | output | 1 | Trigger request to the coincidence logic |
| tot_cnt | output | 20 | Packed slot counts, 10 bits per slot |
| tot_rdy | output | 2 | Per-slot result ready |
| tot_head | output | 1 | Index of the oldest slot |
| tot_ovf | output | 1 | Sticky acknowledge overflow |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes each one. In the first, an acknowledge lands while an earlier measurement is still counting. That cycle must both close the old slot with its partial count and open the next slot, and the bench checks both counts. In the second, an acknowledge and a release are driven on the same edge with both slots taken. The bench expects an overflow, a head that has advanced, and the freed slot cleared. It then checks that a later acknowledge reuses that freed slot.

// File: rtl/lyr_trig_pkg.sv
package lyr_trig_pkg;
  typedef enum logic {
    REQ_FOLLOW  = 1'b0,
    REQ_ONESHOT = 1'b1
  } req_mode_e;
endpackage

// File: rtl/lyr_sync.sv
module lyr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  generate
    if (STAGES > 1) begin : g_chain
      assign ff_d = {ff_q[STAGES-2:0], d};
    end else begin : g_single
      assign ff_d = d;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= ff_d;
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/lyr_req_gen.sv
module lyr_req_gen
  import lyr_trig_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             or_s,
  input  req_mode_e        mode,
  input  logic [LEN_W-1:0] pulse_len,
  output logic             trig_req
);
  logic             or_d_q;
  logic             busy_q, busy_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             rise;
  logic             upd_en;

  assign rise = or_s & ~or_d_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == LEN_W'(1)) busy_d = 1'b0;
    end else if (mode == REQ_ONESHOT && rise && pulse_len != '0) begin
      busy_d = 1'b1;
      cnt_d  = pulse_len;
    end
  end

  assign upd_en = busy_q | rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      or_d_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      or_d_q <= or_s;
      if (upd_en) begin
        busy_q <= busy_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  assign trig_req = (mode == REQ_ONESHOT) ? busy_q : or_s;
endmodule

// File: rtl/lyr_tot_meas.sv
module lyr_tot_meas #(
  parameter int CNT_W     = 10,
  parameter int TOT_LIMIT = 1000,
  parameter int PTR_W     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             or_s,
  input  logic             start,
  input  logic [PTR_W-1:0] start_slot,
  output logic             fin_en,
  output logic [PTR_W-1:0] fin_slot,
  output logic [CNT_W-1:0] fin_cnt
);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(TOT_LIMIT);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] slot_q, slot_d;
  logic             upd_en;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    slot_d = slot_q;
    fin_en = 1'b0;
    if (run_q) begin
      if (start) begin
        fin_en = 1'b1;
      end else if (or_s && cnt_q < LIMIT_C) begin
        cnt_d = cnt_q + 1'b1;
      end else begin
        fin_en = 1'b1;
        run_d  = 1'b0;
      end
    end
    if (start) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      slot_d = start_slot;
    end
  end

  assign upd_en = run_q | start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (upd_en) begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
    end
  end

  assign fin_slot = slot_q;
  assign fin_cnt  = cnt_q;
endmodule

// File: rtl/lyr_tot_slots.sv
module lyr_tot_slots #(
  parameter int CNT_W = 10,
  parameter int NSLOT = 2,
  parameter int PTR_W = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ack,
  input  logic                   release_req,
  input  logic                   fin_en,
  input  logic [PTR_W-1:0]       fin_slot,
  input  logic [CNT_W-1:0]       fin_cnt,
  output logic                   alloc,
  output logic [PTR_W-1:0]       alloc_slot,
  output logic [NSLOT*CNT_W-1:0] cnt_flat,
  output logic [NSLOT-1:0]       rdy,
  output logic [NSLOT-1:0]       resv,
  output logic [PTR_W-1:0]       head,
  output logic                   ovf
);
  logic [NSLOT-1:0] resv_q, resv_d;
  logic [NSLOT-1:0] rdy_q, rdy_d;
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic             ovf_q, ovf_d;
  logic             drop;
  logic             ptr_en;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(NSLOT-1)) ? '0 : p + 1'b1;
  endfunction

  assign alloc      = ack & ~resv_q[wr_q];
  assign alloc_slot = wr_q;
  assign drop       = release_req & rdy_q[rd_q];

  always_comb begin
    resv_d = resv_q;
    rdy_d  = rdy_q;
    wr_d   = wr_q;
    rd_d   = rd_q;
    ovf_d  = ovf_q | (ack & resv_q[wr_q]);
    if (alloc) begin
      resv_d[wr_q] = 1'b1;
      wr_d         = ptr_inc(wr_q);
    end
    if (drop) begin
      resv_d[rd_q] = 1'b0;
      rdy_d[rd_q]  = 1'b0;
      rd_d         = ptr_inc(rd_q);
    end
    if (fin_en) rdy_d[fin_slot] = 1'b1;
  end

  assign ptr_en = alloc | drop | fin_en | ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_q <= '0;
      rdy_q  <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
      ovf_q  <= 1'b0;
    end else if (ptr_en) begin
      resv_q <= resv_d;
      rdy_q  <= rdy_d;
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      ovf_q  <= ovf_d;
    end
  end

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      logic [CNT_W-1:0] val_q;
      logic             wr_en;
      assign wr_en = fin_en && (fin_slot == PTR_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     val_q <= '0;
        else if (wr_en) val_q <= fin_cnt;
      end
      assign cnt_flat[i*CNT_W +: CNT_W] = val_q;
    end
  endgenerate

  assign rdy  = rdy_q;
  assign resv = resv_q;
  assign head = rd_q;
  assign ovf  = ovf_q;
endmodule

// File: rtl/lyr_trig_tot.sv
module lyr_trig_tot
  import lyr_trig_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int CNT_W       = 10,
  parameter int TOT_LIMIT   = 1000,
  parameter int NSLOT       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W      = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   layer_or,
  input  logic                   trig_ack,
  input  logic                   mode_sel,
  input  logic [LEN_W-1:0]       pulse_len,
  input  logic                   slot_release,
  output logic                   trig_req,
  output logic [NSLOT*CNT_W-1:0] tot_cnt,
  output logic [NSLOT-1:0]       tot_rdy,
  output logic [PTR_W-1:0]       tot_head,
  output logic                   tot_ovf
);
  logic [1:0]       rst_ff_q;
  logic             rst_core_n;
  logic             or_s;
  logic             alloc;
  logic [PTR_W-1:0] alloc_slot;
  logic             fin_en;
  logic [PTR_W-1:0] fin_slot;
  logic [CNT_W-1:0] fin_cnt;
  logic [NSLOT-1:0] slot_resv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff_q <= '0;
    else        rst_ff_q <= {rst_ff_q[0], 1'b1};
  end
  assign rst_core_n = rst_ff_q[1];

  lyr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (layer_or),
    .q     (or_s)
  );

  lyr_req_gen #(.LEN_W(LEN_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .or_s      (or_s),
    .mode      (req_mode_e'(mode_sel)),
    .pulse_len (pulse_len),
    .trig_req  (trig_req)
  );

  lyr_tot_meas #(.CNT_W(CNT_W), .TOT_LIMIT(TOT_LIMIT), .PTR_W(PTR_W)) u_meas (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .or_s       (or_s),
    .start      (alloc),
    .start_slot (alloc_slot),
    .fin_en     (fin_en),
    .fin_slot   (fin_slot),
    .fin_cnt    (fin_cnt)
  );

  lyr_tot_slots #(.CNT_W(CNT_W), .NSLOT(NSLOT), .PTR_W(PTR_W)) u_slots (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .ack         (trig_ack),
    .release_req (slot_release),
    .fin_en      (fin_en),
    .fin_slot    (fin_slot),
    .fin_cnt     (fin_cnt),
    .alloc       (alloc),
    .alloc_slot  (alloc_slot),
    .cnt_flat    (tot_cnt),
    .rdy         (tot_rdy),
    .resv        (slot_resv),
    .head        (tot_head),
    .ovf         (tot_ovf)
  );
endmodule

// File: rtl/lyr_trig_tot_chk.sv
module lyr_trig_tot_chk #(
  parameter int LEN_W     = 8,
  parameter int CNT_W     = 10,
  parameter int TOT_LIMIT = 1000,
  parameter int NSLOT     = 2,
  parameter int PTR_W     = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   layer_or,
  input logic                   trig_ack,
  input logic                   mode_sel,
  input logic [LEN_W-1:0]       pulse_len,
  input logic                   slot_release,
  input logic                   trig_req,
  input logic [NSLOT*CNT_W-1:0] tot_cnt,
  input logic [NSLOT-1:0]       tot_rdy,
  input logic [PTR_W-1:0]       tot_head,
  input logic                   tot_ovf,
  input logic [NSLOT-1:0]       slot_resv
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               age_q <= '0;
    else if (age_q != 2'd3)   age_q <= age_q + 1'b1;
  end

  // R2
  pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && !mode_sel) |-> trig_req == $past(layer_or, 2));

  // R5
  oneshot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && $past(mode_sel) && $rose(trig_req)) |-> $past(pulse_len) != '0);

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_lim
      // R8
      tot_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tot_cnt[i*CNT_W +: CNT_W] <= CNT_W'(TOT_LIMIT));
    end
    if (NSLOT > 1) begin : g_adv
      // R9
      head_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_release && tot_rdy[tot_head]) |=> tot_head != $past(tot_head));
    end
  endgenerate

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_release |=> $stable(tot_head));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tot_ovf |=> tot_ovf);

  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_ack && (&slot_resv)) |=> tot_ovf);
endmodule

bind lyr_trig_tot lyr_trig_tot_chk #(
  .LEN_W(LEN_W), .CNT_W(CNT_W), .TOT_LIMIT(TOT_LIMIT), .NSLOT(NSLOT), .PTR_W(PTR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .layer_or     (layer_or),
  .trig_ack     (trig_ack),
  .mode_sel     (mode_sel),
  .pulse_len    (pulse_len),
  .slot_release (slot_release),
  .trig_req     (trig_req),
  .tot_cnt      (tot_cnt),
  .tot_rdy      (tot_rdy),
  .tot_head     (tot_head),
  .tot_ovf      (tot_ovf),
  .slot_resv    (slot_resv)
);

// File: tb/tb_lyr_trig_tot.sv
module tb_lyr_trig_tot;
  localparam int CLK_NS = 20;
  localparam int CNT_W  = 10;

  logic        clk = 1'b0;
  logic        rst_n, layer_or, trig_ack, mode_sel, slot_release;
  logic [7:0]  pulse_len;
  logic        trig_req;
  logic [19:0] tot_cnt;
  logic [1:0]  tot_rdy;
  logic [0:0]  tot_head;
  logic        tot_ovf;

  int n_run = 0;
  int n_fail = 0;

  lyr_trig_tot dut (
    .clk(clk), .rst_n(rst_n), .layer_or(layer_or), .trig_ack(trig_ack),
    .mode_sel(mode_sel), .pulse_len(pulse_len), .slot_release(slot_release),
    .trig_req(trig_req), .tot_cnt(tot_cnt), .tot_rdy(tot_rdy),
    .tot_head(tot_head), .tot_ovf(tot_ovf)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk_eq(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int slot_val(input int i);
    return int'(tot_cnt[i*CNT_W +: CNT_W]);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; layer_or = 1'b0; trig_ack = 1'b0;
    mode_sel = 1'b0; slot_release = 1'b0; pulse_len = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_ack();
    trig_ack = 1'b1; @(negedge clk); trig_ack = 1'b0;
  endtask

  task automatic pulse_rel();
    slot_release = 1'b1; @(negedge clk); slot_release = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_eq("R1 trig_req", int'(trig_req), 0);
    chk_eq("R1 tot_rdy", int'(tot_rdy), 0);
    chk_eq("R1 tot_ovf", int'(tot_ovf), 0);
    chk_eq("R1 tot_head", int'(tot_head), 0);
  endtask

  task automatic t_follow();
    mode_sel = 1'b0;
    layer_or = 1'b1;
    @(negedge clk); chk_eq("R2 rise after 1 edge", int'(trig_req), 0);
    @(negedge clk); chk_eq("R2 rise after 2 edges", int'(trig_req), 1);
    layer_or = 1'b0;
    @(negedge clk); chk_eq("R2 fall after 1 edge", int'(trig_req), 1);
    @(negedge clk); chk_eq("R2 fall after 2 edges", int'(trig_req), 0);
  endtask

  // drives OR pattern over k = 1..len and counts mismatches against [lo,hi]
  task automatic run_window(input string req, input int len, input int lo, input int hi,
                            input int fall_k, input int rerise_k);
    int bad = 0;
    int high = 0;
    layer_or = 1'b1;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      if (trig_req) high++;
      if (int'(trig_req) != ((k >= lo && k <= hi) ? 1 : 0)) bad++;
      if (k == fall_k) layer_or = 1'b0;
      if (k == rerise_k) layer_or = 1'b1;
    end
    chk_eq({req, " window mismatches"}, bad, 0);
    chk_eq({req, " high cycles"}, high, (hi >= lo) ? hi - lo + 1 : 0);
    layer_or = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_oneshot();
    mode_sel = 1'b1; pulse_len = 8'd5;
    repeat (4) @(negedge clk);
    run_window("R3", 20, 3, 7, 0, 0);
  endtask

  task automatic t_no_retrig();
    mode_sel = 1'b1; pulse_len = 8'd6;
    run_window("R4", 24, 3, 8, 2, 4);
  endtask

  task automatic t_zero_len();
    mode_sel = 1'b1; pulse_len = 8'd0;
    run_window("R5", 12, 1, 0, 0, 0);
    mode_sel = 1'b0;
  endtask

  task automatic t_tot_basic();
    do_reset();
    layer_or = 1'b1; repeat (4) @(negedge clk);
    pulse_ack();
    repeat (5) @(negedge clk);
    layer_or = 1'b0;
    repeat (6) @(negedge clk);
    chk_eq("R6 slot0 ready", int'(tot_rdy), 1);
    chk_eq("R6 slot0 count", slot_val(0), 7);
    chk_eq("R6 head", int'(tot_head), 0);
    pulse_rel();
    chk_eq("R9 release clears", int'(tot_rdy), 0);
    chk_eq("R9 head advance", int'(tot_head), 1);
  endtask

  task automatic t_tot_zero();
    repeat (3) @(negedge clk);
    pulse_ack();
    repeat (3) @(negedge clk);
    chk_eq("R7 slot1 ready", int'(tot_rdy), 2);
    chk_eq("R7 slot1 count", slot_val(1), 0);
    pulse_rel();
    chk_eq("R9 head wrap", int'(tot_head), 0);
  endtask

  task automatic t_tot_sat();
    layer_or = 1'b1; repeat (4) @(negedge clk);
    pulse_ack();
    repeat (600) @(negedge clk);
    chk_eq("R8 not ready mid-count", int'(tot_rdy), 0);
    repeat (420) @(negedge clk);
    chk_eq("R8 ready with OR high", int'(tot_rdy), 1);
    chk_eq("R8 saturated count", slot_val(0), 1000);
    pulse_rel();
    layer_or = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic t_order();
    layer_or = 1'b1; repeat (4) @(negedge clk);
    pulse_ack();
    pulse_rel();
    chk_eq("R9 release of busy head ignored", int'(tot_head), 1);
    layer_or = 1'b0;
    repeat (4) @(negedge clk);
    chk_eq("R9 slot1 count", slot_val(1), 3);
    pulse_ack();
    repeat (3) @(negedge clk);
    chk_eq("R9 both ready", int'(tot_rdy), 3);
    chk_eq("R9 head oldest", int'(tot_head), 1);
    pulse_rel();
    chk_eq("R9 first release", int'(tot_rdy), 1);
    chk_eq("R9 head to slot0", int'(tot_head), 0);
    pulse_rel();
    chk_eq("R9 second release", int'(tot_rdy), 0);
  endtask

  task automatic t_full();
    do_reset();
    layer_or = 1'b1; repeat (4) @(negedge clk);
    pulse_ack();
    repeat (3) @(negedge clk);
    layer_or = 1'b0;
    repeat (5) @(negedge clk);
    pulse_ack();
    repeat (3) @(negedge clk);
    chk_eq("R10 both full", int'(tot_rdy), 3);
    layer_or = 1'b1; repeat (4) @(negedge clk);
    pulse_ack();
    repeat (10) @(negedge clk);
    chk_eq("R10 overflow set", int'(tot_ovf), 1);
    chk_eq("R10 slot0 kept", slot_val(0), 5);
    chk_eq("R10 slot1 kept", slot_val(1), 0);
    chk_eq("R10 head kept", int'(tot_head), 0);
    pulse_rel(); pulse_rel();
    chk_eq("R10 overflow sticky", int'(tot_ovf), 1);
    layer_or = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic t_ack_in_run();
    do_reset();
    layer_or = 1'b1; repeat (4) @(negedge clk);
    pulse_ack();
    repeat (3) @(negedge clk);
    trig_ack = 1'b1; @(negedge clk); trig_ack = 1'b0;
    layer_or = 1'b0;
    chk_eq("R11 old slot closed", int'(tot_rdy), 1);
    chk_eq("R11 old partial count", slot_val(0), 3);
    repeat (5) @(negedge clk);
    chk_eq("R11 new slot ready", int'(tot_rdy), 3);
    chk_eq("R11 new count", slot_val(1), 2);
  endtask

  task automatic t_same_cycle();
    do_reset();
    repeat (3) @(negedge clk);
    pulse_ack();
    repeat (2) @(negedge clk);
    pulse_ack();
    repeat (3) @(negedge clk);
    chk_eq("R12 both full", int'(tot_rdy), 3);
    trig_ack = 1'b1; slot_release = 1'b1;
    @(negedge clk);
    trig_ack = 1'b0; slot_release = 1'b0;
    chk_eq("R12 overflow", int'(tot_ovf), 1);
    chk_eq("R12 head advanced", int'(tot_head), 1);
    chk_eq("R12 slot0 freed", int'(tot_rdy), 2);
    pulse_ack();
    repeat (3) @(negedge clk);
    chk_eq("R12 freed slot reused", int'(tot_rdy), 3);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; layer_or = 1'b0; trig_ack = 1'b0;
    mode_sel = 1'b0; slot_release = 1'b0; pulse_len = 8'd0;
    t_reset();
    t_follow();
    t_oneshot();
    t_no_retrig();
    t_zero_len();
    t_tot_basic();
    t_tot_zero();
    t_tot_sat();
    t_order();
    t_full();
    t_ack_in_run();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule